// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Level and Edge Pin Interrupts

This block is one general-purpose I/O port of a microcontroller. Each of its pins takes its own mode from three per-bit control registers: a direction register and two alternate-select registers. A data register completes the mode. For an output pin it holds the value driven. For an interrupt pin its bit selects the polarity. A write-one acknowledge register clears edge requests. Software reaches all registers through a plain single-cycle register interface. Writes take effect at the clock edge where `bus_we` is high. Reads are combinational from `bus_addr`.

Pin inputs pass through a two-flop synchronizer before any use. A pin in level-interrupt mode raises its request only after the synchronized pin has shown the active level on two consecutive samples. The request falls as soon as the level goes away. A pin in edge-interrupt mode latches a request on the selected edge, and the request stays set until software acknowledges it. The per-pin requests come out on their own bus, and their OR comes out as one interrupt line. No port carries streaming data, so every pin is a plain control or status signal and has no back-pressure.

Top module: `gpio_port`

## Requirements
- R1: After reset, direction reads 0xFF at address 1. The alternate-1 (address 2), alternate-2 (address 3), data (address 6) and request status (address 5) registers read 0x00. `pin_oe`, `irq_bits` and `irq` are all zero.
- R2: A pin with {alt2, alt1, dir} = 000 is an output. Its `pin_oe` bit is 1 and `pin_out` carries its data-register bit. Every other mode leaves `pin_oe` at 0.
- R3: A read of address 0 returns the pin levels through a two-flop synchronizer. A pin change made after one rising edge shows at address 0 after the second rising edge that follows it, and not after the first.
- R4: A pin with {alt2, alt1, dir} = 110 is in level-interrupt mode. Data bit 1 selects active high and data bit 0 selects active low. A pin change to the active level raises its `irq_bits` bit after the third rising edge that follows it, and not after the second.
- R5: A level request falls without any software action, after the second rising edge that follows the pin leaving the active level.
- R6: In level mode, an active-level pulse that lasts one clock period never raises a request.
- R7: A pin with {alt2, alt1, dir} = 111 is in edge-interrupt mode. Data bit 1 selects rising edges and data bit 0 selects falling edges. The selected edge sets the request after the third rising edge that follows it. The opposite edge sets nothing.
- R8: An edge request stays set, even after the pin returns, until a write to address 4 carries a 1 in that pin's bit. A 0 in that bit leaves the request set.
- R9: An edge request latched in edge mode stays set after the pin moves to level mode and the level goes inactive. A write of 1 to the pin's bit at address 4 clears it.
- R10: `irq` is the OR of `irq_bits`, and address 5 reads `irq_bits`. Several pins can request at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output levels |
| pin_oe | output | 8 | Pad output enables |
| irq_bits | output | 8 | Per-pin interrupt requests |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: eight pins and a three-bit address. With eight pins, distinct pins can sit in output, level and edge modes at the same time. Several pins can then raise requests together, so the combined line and the status register are exercised with more than one active bit. The three-bit address reaches every register, including the acknowledge and status locations.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int ADDR_W = 3;

  // Register locations
  localparam logic [ADDR_W-1:0] A_PINS   = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIR    = 3'd1;
  localparam logic [ADDR_W-1:0] A_ALT1   = 3'd2;
  localparam logic [ADDR_W-1:0] A_ALT2   = 3'd3;
  localparam logic [ADDR_W-1:0] A_ACK    = 3'd4;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd5;
  localparam logic [ADDR_W-1:0] A_DATA   = 3'd6;

  typedef struct packed {
    logic drive;
    logic lvl;
    logic edg;
  } pin_mode_t;

  // Decode {alt2, alt1, dir} into the behaviours this port supports
  function automatic pin_mode_t decode_mode(input logic a2, input logic a1, input logic dir);
    pin_mode_t m;
    m = '0;
    unique case ({a2, a1, dir})
      3'b000:  m.drive = 1'b1;
      3'b110:  m.lvl   = 1'b1;
      3'b111:  m.edg   = 1'b1;
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_pin_irq.sv
module gpio_pin_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic lvl_en,
  input  logic edg_en,
  input  logic pol,
  input  logic ack,
  output logic req
);
  logic prev_q;
  logic latch_q;
  logic edge_seen;
  logic lvl_hit;

  assign edge_seen = edg_en && (pin_s != prev_q) && (pin_s == pol);
  assign lvl_hit   = lvl_en && (pin_s == pol) && (prev_q == pol);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q <= pin_s;
      if (edge_seen)
        latch_q <= 1'b1;
      else if (ack)
        latch_q <= 1'b0;
    end
  end

  assign req = lvl_hit | latch_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      pins_s,
  input  logic [W-1:0]      req,
  output logic [W-1:0]      rdata,
  output logic [W-1:0]      data_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      alt1_q,
  output logic [W-1:0]      alt2_q,
  output logic [W-1:0]      ack
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '1;
      alt1_q <= '0;
      alt2_q <= '0;
    end else if (we) begin
      case (addr)
        A_PINS:  data_q <= wdata;
        A_DATA:  data_q <= wdata;
        A_DIR:   dir_q  <= wdata;
        A_ALT1:  alt1_q <= wdata;
        A_ALT2:  alt2_q <= wdata;
        default: ;
      endcase
    end
  end

  assign ack = (we && addr == A_ACK) ? wdata : '0;

  always_comb begin
    unique case (addr)
      A_PINS:   rdata = pins_s;
      A_DIR:    rdata = dir_q;
      A_ALT1:   rdata = alt1_q;
      A_ALT2:   rdata = alt2_q;
      A_STATUS: rdata = req;
      A_DATA:   rdata = data_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  irq_bits,
  output logic              irq
);
  logic [NPINS-1:0] pins_s;
  logic [NPINS-1:0] data_q, dir_q, alt1_q, alt2_q, ack;
  logic [NPINS-1:0] mode_lvl, mode_edge;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pins_s)
  );

  gpio_regs #(.W(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .pins_s(pins_s), .req(irq_bits), .rdata(bus_rdata),
    .data_q(data_q), .dir_q(dir_q), .alt1_q(alt1_q), .alt2_q(alt2_q), .ack(ack)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    pin_mode_t m;
    assign m            = decode_mode(alt2_q[i], alt1_q[i], dir_q[i]);
    assign pin_oe[i]    = m.drive;
    assign mode_lvl[i]  = m.lvl;
    assign mode_edge[i] = m.edg;

    gpio_pin_irq u_irq (
      .clk(clk), .rst_n(rst_n), .pin_s(pins_s[i]),
      .lvl_en(m.lvl), .edg_en(m.edg), .pol(data_q[i]),
      .ack(ack[i]), .req(irq_bits[i])
    );
  end

  assign pin_out = data_q;
  assign irq     = |irq_bits;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_pkg::*;
#(
  parameter int NPINS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPINS-1:0]  bus_wdata,
  input logic [NPINS-1:0]  pin_oe,
  input logic [NPINS-1:0]  irq_bits,
  input logic [NPINS-1:0]  mode_lvl,
  input logic [NPINS-1:0]  mode_edge
);
  logic seen_edge = 1'b0;
  always @(posedge clk) seen_edge <= 1'b1;

  // R1: while held in reset the port drives nothing and requests nothing
  always @(negedge clk) begin
    if (seen_edge && !rst_n)
      a_r1_reset_quiet: assert (pin_oe == '0 && irq_bits == '0);
  end

  logic [NPINS-1:0] ack_hit;
  assign ack_hit = (bus_we && bus_addr == A_ACK) ? bus_wdata : '0;

  for (genvar i = 0; i < NPINS; i++) begin : g_chk
    // R8: an edge request survives every cycle without an acknowledge
    a_r8_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_edge[i] && irq_bits[i] && !ack_hit[i]) |=> irq_bits[i]);

    // R9: acknowledge outside the interrupt modes leaves no request
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit[i] && !mode_edge[i] && !mode_lvl[i]) |=> !irq_bits[i]);

    // R4 / R7: a request can only appear from an interrupt mode
    a_r7_rise_needs_irq_mode: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_bits[i]) |-> (mode_lvl[i] || $past(mode_edge[i])));

    // R2: no pin drives while it is in an interrupt mode
    a_r2_irq_pin_undriven: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_lvl[i] || mode_edge[i]) |-> !pin_oe[i]);
  end
endmodule

bind gpio_port gpio_port_chk #(.NPINS(NPINS)) u_chk (.*);

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out, pin_oe, irq_bits;
  logic       irq;

  int n_cmp = 0;
  int n_bad = 0;
  int pending = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_bits(irq_bits), .irq(irq)
  );

  // kinds: 0 read data, 1 irq_bits, 2 irq, 3 pin_oe, 4 pin_out
  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sb[$];

  // Monitor: compares everything queued at the next falling edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb.pop_front();
      case (it.kind)
        0:       act = bus_rdata;
        1:       act = irq_bits;
        2:       act = {7'd0, irq};
        3:       act = pin_oe;
        default: act = pin_out;
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp);
      end
      pending--;
    end
  end

  task automatic push(input int kind, input logic [7:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    pending++;
  endtask

  task automatic flush();
    wait (pending == 0);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a;
    push(0, exp, tag);
    flush();
  endtask

  task automatic chk_bits(input logic [7:0] exp, input string tag);
    push(1, exp, tag);
    flush();
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    step(1);
    bus_we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    step(4);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    rd(3'd1, 8'hFF, "R1 dir");
    rd(3'd2, 8'h00, "R1 alt1");
    rd(3'd3, 8'h00, "R1 alt2");
    rd(3'd6, 8'h00, "R1 data");
    rd(3'd5, 8'h00, "R1 status");
    push(2, 8'h00, "R1 irq"); push(3, 8'h00, "R1 oe"); flush();

    // R2 output drive
    wr(3'd1, 8'hF0);
    wr(3'd6, 8'hA5);
    push(3, 8'h0F, "R2 oe"); push(4, 8'hA5, "R2 out"); flush();
    wr(3'd3, 8'h01);
    push(3, 8'h0E, "R2 mode100 not driven"); flush();
    wr(3'd3, 8'h00); wr(3'd1, 8'hFF); wr(3'd6, 8'h00);
    push(3, 8'h00, "R2 inputs undriven"); flush();

    // R3 synchronized readback
    pin_in = 8'h3C;
    step(1);
    rd(3'd0, 8'h00, "R3 one edge");
    step(1);
    rd(3'd0, 8'h3C, "R3 two edges");
    pin_in = 8'h00;
    step(3);

    // R4 level mode on pin 1, active high, entered through edge mode
    wr(3'd6, 8'h02); wr(3'd3, 8'h02); wr(3'd2, 8'h02); wr(3'd1, 8'hFD);
    wr(3'd4, 8'h02);
    chk_bits(8'h00, "R4 idle");
    pin_in = 8'h02;
    step(2);
    chk_bits(8'h00, "R4 after two edges");
    step(1);
    push(1, 8'h02, "R4 after three edges"); push(2, 8'h01, "R10 irq"); flush();
    rd(3'd5, 8'h02, "R10 status");
    // R5 drop without software
    pin_in = 8'h00;
    step(1);
    chk_bits(8'h02, "R5 one edge still set");
    step(1);
    chk_bits(8'h00, "R5 dropped");
    // R4 active low
    wr(3'd6, 8'h00);
    chk_bits(8'h02, "R4 active low");
    wr(3'd6, 8'h02);
    chk_bits(8'h00, "R4 back to active high");

    // R6 one-cycle pulse
    pin_in = 8'h02;
    step(1);
    pin_in = 8'h00;
    for (int k = 0; k < 4; k++) begin
      step(1);
      chk_bits(8'h00, "R6 pulse ignored");
    end

    // R7 edge mode on pin 4, rising
    wr(3'd6, 8'h12); wr(3'd3, 8'h12); wr(3'd2, 8'h12); wr(3'd4, 8'h10);
    chk_bits(8'h00, "R7 idle");
    pin_in = 8'h10;
    step(2);
    chk_bits(8'h00, "R7 rising two edges");
    step(1);
    chk_bits(8'h10, "R7 rising set");
    // R8 sticky and acknowledge
    pin_in = 8'h00;
    step(3);
    chk_bits(8'h10, "R8 held after fall");
    wr(3'd4, 8'hEF);
    chk_bits(8'h10, "R8 ack with zero ignored");
    wr(3'd4, 8'h10);
    chk_bits(8'h00, "R8 ack clears");
    // R7 falling selection
    wr(3'd6, 8'h02);
    pin_in = 8'h10;
    step(4);
    chk_bits(8'h00, "R7 rising ignored when falling chosen");
    pin_in = 8'h00;
    step(3);
    chk_bits(8'h10, "R7 falling set");
    wr(3'd4, 8'h10);
    chk_bits(8'h00, "R7 cleared");

    // R9 stray request while moving to level mode
    wr(3'd6, 8'h12);
    pin_in = 8'h10;
    step(3);
    chk_bits(8'h10, "R9 stray latched");
    wr(3'd1, 8'hED);
    pin_in = 8'h00;
    step(3);
    chk_bits(8'h10, "R9 stray held in level mode");
    wr(3'd4, 8'h10);
    chk_bits(8'h00, "R9 ack clears stray");

    // R10 two pins together
    pin_in = 8'h12;
    step(3);
    push(1, 8'h12, "R10 two requests"); push(2, 8'h01, "R10 combined"); flush();
    rd(3'd5, 8'h12, "R10 status two");
    pin_in = 8'h00;
    step(2);
    push(1, 8'h00, "R10 both dropped"); push(2, 8'h00, "R10 combined low"); flush();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule